// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital side of a successive-approximation converter. Software sees one 8-bit control and status byte. The block divides the system clock down to a converter clock and times each conversion in converter clocks. A conversion can be launched by a register write, by a rising edge on an external trigger line, or by chaining one conversion after another. When a conversion ends, the block latches the sample word presented on `sample_in`, sets a completion flag and can raise an interrupt request.

The analog array is not part of the block. The surrounding logic presents a sample word, and the block captures it on the clock edge that ends the timed conversion. Software reads and writes the control byte through a plain single-cycle write strobe and a combinational read image. An acknowledge input lets an interrupt controller retire the flag.

Top module: `sar_conv_ctrl`

## Requirements
- R1: The control byte is laid out as follows: bit 7 enable, bit 6 start/busy, bit 5 auto-trigger, bit 4 done flag, bit 3 interrupt enable, bits 2:0 clock divider code. After reset every bit, the result word and `irq` are zero.
- R2: The divider code sets how many system clocks make one converter clock. Codes 0 and 1 both give 2. A code k from 2 to 7 gives 2^k. The divider is held cleared while the block is disabled, so the first converter clock after enabling arrives a full divide period later.
- R3: A conversion lasts 13 converter clocks. The first conversion after enabling lasts 25 converter clocks instead. This includes a conversion started by the same write that sets enable.
- R4: Bit 6 reads 1 from the cycle after a start until the cycle after completion. Writing 0 to it, or writing 1 to it while a conversion is running, changes nothing.
- R5: Writing 0 to bit 7 clears enable and busy on the next edge. The running conversion produces no flag and no new result.
- R6: On the edge that ends a conversion, `result` takes the value of `sample_in` and bit 4 becomes 1. At all other times `result` holds its value.
- R7: Bit 4 is cleared by writing 1 to it or by a one-cycle `irq_ack` pulse. Writing 0 leaves it unchanged. If completion and a clear fall on the same edge, completion wins.
- R8: `irq` is 1 exactly when bit 4, bit 3 and the `gie` input are all 1.
- R9: With bit 5 set and `free_run` low, a rising edge on `trig_in` while idle starts a conversion, and busy shows on the following cycle. An edge that arrives while a conversion is running is dropped and not queued.
- R10: With bit 5 set and `free_run` high, one start write launches conversions that follow back-to-back. Busy stays 1 and the result updates every 13 converter clocks after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control byte |
| reg_wdata | input | 8 | Write data for the control byte |
| reg_rdata | output | 8 | Read image of the control byte |
| trig_in | input | 1 | External start trigger, rising edge |
| free_run | input | 1 | Chains conversions when auto-trigger is set |
| sample_in | input | RES_W | Sample word from the converter array |
| result | output | RES_W | Last completed sample |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Interrupt request |

## Verification
A register write shows in the read image one edge after the strobe. A start, by write or by a trigger edge, shows as busy one edge later. Completion, flag and result all land on the edge of the last converter clock of the conversion, so with the divider reset at enable the first conversion takes exactly 25 × divide system cycles. The `irq` output follows `gie` without delay. A behavioural model in the bench advances on the rising edge from the same inputs, and every output is compared 5 ns after the falling edge. Directed checks measure busy windows in whole cycles against those counts.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

   // control byte image, most significant field first
   typedef struct packed {
      logic       en;
      logic       go;
      logic       autot;
      logic       flag;
      logic       ie;
      logic [2:0] ps;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int CNT_W = (1 << CODE_W) - 1;
   localparam int SPN_W = CNT_W + 1;

   if (CODE_W < 2 || CODE_W > 4) begin : g_bad_code
      $error("sar_clk_div: CODE_W out of range");
   end

   logic [CNT_W-1:0]  cnt;
   logic [CODE_W-1:0] sh;
   logic [SPN_W-1:0]  span;
   logic [SPN_W-1:0]  lim;

   always_comb begin
      sh   = (code < CODE_W'(2)) ? CODE_W'(1) : code;
      span = SPN_W'(1) << sh;
      lim  = span - SPN_W'(1);
   end

   // >= keeps a mid-count code change from overrunning the counter
   assign tick = run && ({1'b0, cnt} >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
   parameter int LEN_NORM  = 13,
   parameter int LEN_FIRST = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_nxt,
   input  logic tick,
   input  logic start,
   input  logic chain,
   output logic busy,
   output logic done
);
   localparam int CNT_W = $clog2(LEN_FIRST);

   if (LEN_NORM < 2 || LEN_FIRST < LEN_NORM) begin : g_bad_len
      $error("sar_conv_timer: conversion lengths inconsistent");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic             first;

   assign last = first ? CNT_W'(LEN_FIRST - 1) : CNT_W'(LEN_NORM - 1);
   assign done = busy && tick && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt   <= '0;
         first <= 1'b1;
      end else if (!en_nxt) begin
         busy  <= 1'b0;
         cnt   <= '0;
         first <= 1'b1;
      end else if (done) begin
         busy  <= chain;
         cnt   <= '0;
         first <= 1'b0;
      end else if (busy) begin
         if (tick) cnt <= cnt + 1'b1;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end
   end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
   import sar_ctrl_pkg::*;
#(
   parameter int RES_W     = 10,
   parameter int LEN_NORM  = 13,
   parameter int LEN_FIRST = 25,
   parameter bit TRIG_SYNC = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             trig_in,
   input  logic             free_run,
   input  logic [RES_W-1:0] sample_in,
   output logic [RES_W-1:0] result,
   input  logic             gie,
   input  logic             irq_ack,
   output logic             irq
);
   if (CTRL_W != 8 || RES_W < 1) begin : g_bad_cfg
      $error("sar_conv_ctrl: bad configuration");
   end

   ctrl_t      wv;
   logic       en_q, auto_q, flag_q, ie_q;
   logic [2:0] ps_q;
   logic       en_nxt, adc_tick, busy, done, done_ok, start, chain;
   logic       trig_s, trig_q, rise;

   assign wv     = ctrl_t'(reg_wdata);
   assign en_nxt = reg_wr ? wv.en : en_q;

   if (TRIG_SYNC) begin : g_sync
      logic s1, s2;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
         end else begin
            s1 <= trig_in;
            s2 <= s1;
         end
      end
      assign trig_s = s2;
   end else begin : g_direct
      assign trig_s = trig_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= trig_s;
   end
   assign rise = trig_s & ~trig_q;

   assign start   = en_nxt && ((reg_wr && wv.go) || (auto_q && !free_run && rise));
   assign chain   = auto_q && free_run;
   assign done_ok = done && en_nxt;

   sar_clk_div #(.CODE_W(3)) div_i (
      .clk(clk), .rst_n(rst_n), .run(en_q), .code(ps_q), .tick(adc_tick)
   );

   sar_conv_timer #(.LEN_NORM(LEN_NORM), .LEN_FIRST(LEN_FIRST)) tmr_i (
      .clk(clk), .rst_n(rst_n), .en_nxt(en_nxt), .tick(adc_tick),
      .start(start), .chain(chain), .busy(busy), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         auto_q <= 1'b0;
         ie_q   <= 1'b0;
         ps_q   <= '0;
         flag_q <= 1'b0;
         result <= '0;
      end else begin
         if (reg_wr) begin
            en_q   <= wv.en;
            auto_q <= wv.autot;
            ie_q   <= wv.ie;
            ps_q   <= wv.ps;
         end
         if (done_ok)                           flag_q <= 1'b1;
         else if ((reg_wr && wv.flag) || irq_ack) flag_q <= 1'b0;
         if (done_ok) result <= sample_in;
      end
   end

   assign reg_rdata = ctrl_t'{en: en_q, go: busy, autot: auto_q, flag: flag_q,
                              ie: ie_q, ps: ps_q};
   assign irq = flag_q & ie_q & gie;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
   parameter int RES_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             wr_en_bit,
   input logic [7:0]       reg_rdata,
   input logic             irq_ack,
   input logic             irq,
   input logic             conv_done,
   input logic             adc_tick,
   input logic [RES_W-1:0] sample_in,
   input logic [RES_W-1:0] result
);
   p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      adc_tick |=> !adc_tick);

   p_busy_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[6] |-> reg_rdata[7]);

   p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !wr_en_bit) |=> (!reg_rdata[6] && !reg_rdata[7]));

   p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> (reg_rdata[4] && result == $past(sample_in)));

   p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> $stable(result));

   p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !conv_done) |=> !reg_rdata[4]);

   p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (reg_rdata[4] && reg_rdata[3]));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_W(RES_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .wr_en_bit(reg_wdata[7]),
   .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq(irq), .conv_done(done_ok),
   .adc_tick(adc_tick), .sample_in(sample_in), .result(result)
);

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
   localparam int RW = 10;
   localparam logic [7:0] EN = 8'h80, GO = 8'h40, AT = 8'h20, FL = 8'h10, IE = 8'h08;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n = 1'b0, reg_wr = 1'b0, trig = 1'b0, fr = 1'b0, gie = 1'b0, ack = 1'b0;
   logic [7:0]    wd = '0;
   logic [RW-1:0] smp = '0;
   wire  [7:0]    rd;
   wire  [RW-1:0] res;
   wire           irq;

   sar_conv_ctrl #(.RES_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(wd), .reg_rdata(rd),
      .trig_in(trig), .free_run(fr), .sample_in(smp), .result(res),
      .gie(gie), .irq_ack(ack), .irq(irq)
   );

   int n_cmp = 0, n_bad = 0;
   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit m_en, m_busy, m_ate, m_flag, m_ie, m_first, m_tq;
   logic [2:0] m_ps;
   logic [RW-1:0] m_res;
   int m_pc, m_cc;
   int dv, ln;
   bit tk, dn, en_n, rise, sreq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_busy = 0; m_ate = 0; m_flag = 0; m_ie = 0; m_first = 1;
         m_tq = 0; m_ps = '0; m_res = '0; m_pc = 0; m_cc = 0;
      end else begin
         dv   = (m_ps < 2) ? 2 : (1 << m_ps);
         tk   = m_en && (m_pc >= dv - 1);
         ln   = m_first ? 25 : 13;
         dn   = m_busy && tk && (m_cc == ln - 1);
         en_n = reg_wr ? wd[7] : m_en;
         rise = trig && !m_tq;
         sreq = (reg_wr && wd[6]) || (m_ate && !fr && rise);
         m_pc = (!m_en || tk) ? 0 : m_pc + 1;
         m_tq = trig;
         if (!en_n) begin
            m_busy = 0; m_cc = 0; m_first = 1;
         end else if (dn) begin
            m_busy = m_ate && fr; m_cc = 0; m_first = 0;
         end else if (m_busy) begin
            if (tk) m_cc++;
         end else if (sreq) begin
            m_busy = 1; m_cc = 0;
         end
         if (dn && en_n) begin
            m_flag = 1; m_res = smp;
         end else if ((reg_wr && wd[4]) || ack) m_flag = 0;
         if (reg_wr) begin
            m_en = wd[7]; m_ate = wd[5]; m_ie = wd[3]; m_ps = wd[2:0];
         end
      end
   end

   // sample stream changes at the falling edge
   always @(negedge clk) smp = RW'((smp * 5 + 3) % 1024);

   // per-cycle comparison away from the active edge
   always begin
      @(negedge clk);
      #5;
      if (rst_n) begin
         chk("R1 register image", int'(rd), int'({m_en, m_busy, m_ate, m_flag, m_ie, m_ps}));
         chk("R6 result word", int'(res), int'(m_res));
         chk("R8 irq", int'(irq), int'(m_flag & m_ie & gie));
      end
   end

   task automatic wr(input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; wd = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic busy_len(output int n);
      n = 0;
      while (rd[6] && n < 20000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      int n, chg;
      logic [RW-1:0] prv;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #5;
      chk("R1 reset byte", int'(rd), 0);
      chk("R1 reset result", int'(res), 0);
      chk("R1 reset irq", int'(irq), 0);

      // R3: enable and start together, divide-by-2
      wr(EN | GO);
      busy_len(n);
      chk("R3 first conversion 25 clocks x2", n, 50);
      chk("R6 flag after completion", int'(rd[4]), 1);

      // R3: next conversion is 13 clocks; R7: writing 0 to flag keeps it
      wr(EN | GO);
      chk("R7 zero write keeps flag", int'(rd[4]), 1);
      busy_len(n);
      chk("R3 normal conversion 13 clocks x2", int'(n >= 25 && n <= 26), 1);

      // R4: zero write to start while busy
      wr(EN | GO);
      wr(EN);
      chk("R4 zero start write no effect", int'(rd[6]), 1);
      busy_len(n);
      chk("R4 busy clears at completion", int'(rd[6]), 0);

      // R7: clear by writing one
      wr(EN | FL);
      chk("R7 write one clears flag", int'(rd[4]), 0);

      // R8 and ack path
      gie = 1'b1;
      wr(EN | IE | GO);
      busy_len(n);
      #5 chk("R8 irq raised", int'(irq), 1);
      @(negedge clk); gie = 1'b0;
      #5 chk("R8 irq masked by gie", int'(irq), 0);
      @(negedge clk); gie = 1'b1; ack = 1'b1;
      @(negedge clk); ack = 1'b0;
      #5 chk("R7 ack clears flag", int'(rd[4]), 0);

      // R5: abort
      wr(EN | GO);
      repeat (10) @(negedge clk);
      wr(8'h00);
      chk("R5 abort clears enable and busy", int'(rd[7:6]), 0);
      repeat (60) @(negedge clk);
      chk("R5 no flag after abort", int'(rd[4]), 0);

      // R2: divider codes
      wr(EN | GO | 8'd1);
      busy_len(n);
      chk("R2 code 1 divides by 2", n, 50);
      wr(FL);
      wr(EN | GO | 8'd3);
      busy_len(n);
      chk("R2 code 3 divides by 8", n, 200);
      wr(FL);
      wr(EN | GO | 8'd7);
      busy_len(n);
      chk("R2 code 7 divides by 128", n, 3200);
      wr(FL);

      // R9: external trigger
      wr(EN | AT);
      repeat (60) @(negedge clk);
      chk("R9 no edge no start", int'(rd[6]), 0);
      trig = 1'b1;
      @(negedge clk);
      chk("R9 rising edge starts", int'(rd[6]), 1);
      trig = 1'b0;
      repeat (5) @(negedge clk);
      trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      busy_len(n);
      repeat (2) @(negedge clk);
      chk("R9 edge while busy not queued", int'(rd[6]), 0);
      wr(FL);

      // R10: free-running chain
      fr = 1'b1;
      wr(EN | AT | GO);
      chg = 0; n = 0; prv = res;
      for (int i = 0; i < 150; i++) begin
         if (!rd[6]) n++;
         if (res != prv) chg++;
         prv = res;
         @(negedge clk);
      end
      chk("R10 busy never drops", n, 0);
      chk("R10 four chained completions", chg, 4);
      fr = 1'b0;
      wr(FL);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule